// File: doc/BRIEF.md
# Dual-Lane Block Sample Distributor

This block takes one stream of complex samples and splits it across two output lanes. Each input beat carries one 32-bit complex sample. Accepted samples are grouped into blocks of four consecutive samples. Every sample of a block leaves on the same lane, and the lanes take turns block by block. The downstream filter stage reads the two lanes in alternation, so each lane needs only half of the aggregate sample rate.

Two build-time options keep the two lanes paired correctly for a downstream stage that starts at a different point of the stream:

- A start-lane swap sends the first forwarded block to lane 1 instead of lane 0.
- A skip count drops a number of whole four-sample blocks at the start. The dropped samples are consumed at the input and never appear on a lane.

The block holds no data. Routing and the ready path are combinational, and only the block position, the current lane and the remaining skip count are registered.

Top module: `dsd_block_distributor`

## Requirements
- R1: A forwarded sample appears unchanged on its lane. The real part is bits [31:16] and the imaginary part is bits [15:0].
- R2: Every BLK_LEN (default 4) consecutive forwarded samples share one lane, and the next block goes to the other lane.
- R3: With SWAP_START=0 and SKIP_BLKS=0, accepted samples 0-3 go to lane 0, samples 4-7 go to lane 1, samples 8-11 go to lane 0, and so on.
- R4: With SWAP_START=1, the first forwarded block goes to lane 1, and alternation continues from there.
- R5: The first SKIP_BLKS whole blocks are consumed with in_ready high and no lane valid. Forwarding then begins at the start lane.
- R6: At most one lane is valid in any cycle, and a lane is valid only while in_valid is high.
- R7: in_ready follows only the ready of the lane that the next sample is headed for. The other lane's ready has no effect.
- R8: A synchronous active-high reset returns the block position to 0, the lane to the start lane, and reloads the skip count.
- R9: The block adds no latency. A sample offered in a cycle is presented on its lane in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input sample valid |
| in_ready | output | 1 | Input sample accepted when high together with in_valid |
| in_data | input | 32 | Complex sample: real [31:16], imaginary [15:0] |
| lane0_valid | output | 1 | Lane 0 sample valid |
| lane0_ready | input | 1 | Lane 0 consumer ready |
| lane0_data | output | 32 | Lane 0 sample |
| lane1_valid | output | 1 | Lane 1 sample valid |
| lane1_ready | input | 1 | Lane 1 consumer ready |
| lane1_data | output | 32 | Lane 1 sample |

## Verification
Lane valids, lane data and in_ready are combinational from the inputs and the registered position, so they are due in the same cycle as the stimulus. The position and lane state move on the first clock edge after a handshake. The bench therefore drives inputs one time unit after the rising edge and compares all outputs at the falling edge of that same cycle. Its reference sample count advances only after that comparison, when the bench's own expected handshake occurred, so a sample's lane is predicted from how many samples were accepted before it.

// File: rtl/dsd_pkg.sv
`timescale 1ns/1ps
package dsd_pkg;

    localparam int PART_W   = 16;
    localparam int SAMPLE_W = 2 * PART_W;
    localparam int NUM_LANES = 2;

    typedef struct packed {
        logic signed [PART_W-1:0] re;
        logic signed [PART_W-1:0] im;
    } cplx_t;

    typedef enum logic {
        LANE0 = 1'b0,
        LANE1 = 1'b1
    } lane_e;

    typedef struct packed {
        lane_e lane;
        logic  skipping;
    } route_t;

    function automatic lane_e other_lane(lane_e l);
        return (l == LANE0) ? LANE1 : LANE0;
    endfunction

endpackage

// File: rtl/dsd_block_tracker.sv
`timescale 1ns/1ps
module dsd_block_tracker
    import dsd_pkg::*;
#(
    parameter int BLK_LEN    = 4,
    parameter int SKIP_BLKS  = 0,
    parameter bit SWAP_START = 1'b0
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   adv,
    output route_t route
);
    localparam int POS_W  = $clog2(BLK_LEN);
    localparam int SKIP_W = $clog2(SKIP_BLKS + 2);
    localparam logic [POS_W-1:0]  LAST_POS  = POS_W'(BLK_LEN - 1);
    localparam logic [SKIP_W-1:0] SKIP_INIT = SKIP_W'(SKIP_BLKS);
    localparam lane_e START_LANE = SWAP_START ? LANE1 : LANE0;

    logic [POS_W-1:0] pos_q;
    lane_e            lane_q;
    logic             blk_end;
    logic             skipping;

    assign blk_end = adv && (pos_q == LAST_POS);

    always_ff @(posedge clk) begin
        if (rst) begin
            pos_q <= '0;
        end else if (adv) begin
            pos_q <= (pos_q == LAST_POS) ? '0 : pos_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            lane_q <= START_LANE;
        end else if (blk_end && !skipping) begin
            lane_q <= other_lane(lane_q);
        end
    end

    generate
        if (SKIP_BLKS > 0) begin : g_skip
            logic [SKIP_W-1:0] skip_q;
            always_ff @(posedge clk) begin
                if (rst) begin
                    skip_q <= SKIP_INIT;
                end else if (blk_end && skipping) begin
                    skip_q <= skip_q - 1'b1;
                end
            end
            assign skipping = (skip_q != '0);
        end else begin : g_noskip
            assign skipping = 1'b0;
        end
    endgenerate

    assign route.lane     = lane_q;
    assign route.skipping = skipping;

endmodule

// File: rtl/dsd_lane_router.sv
`timescale 1ns/1ps
module dsd_lane_router
    import dsd_pkg::*;
(
    input  logic                  in_valid,
    input  cplx_t                 in_data,
    input  route_t                route,
    input  logic [NUM_LANES-1:0]  lane_ready,
    output logic [NUM_LANES-1:0]  lane_valid,
    output cplx_t [NUM_LANES-1:0] lane_data,
    output logic                  in_ready,
    output logic                  adv
);
    generate
        for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
            assign lane_valid[g] = in_valid && !route.skipping
                                   && (route.lane == lane_e'(1'(g)));
            assign lane_data[g]  = in_data;
        end
    endgenerate

    assign in_ready = route.skipping | lane_ready[route.lane];
    assign adv      = in_valid & in_ready;

endmodule

// File: rtl/dsd_block_distributor.sv
`timescale 1ns/1ps
module dsd_block_distributor
    import dsd_pkg::*;
#(
    parameter int BLK_LEN    = 4,
    parameter int SKIP_BLKS  = 0,
    parameter bit SWAP_START = 1'b0
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                in_valid,
    output logic                in_ready,
    input  logic [SAMPLE_W-1:0] in_data,
    output logic                lane0_valid,
    input  logic                lane0_ready,
    output logic [SAMPLE_W-1:0] lane0_data,
    output logic                lane1_valid,
    input  logic                lane1_ready,
    output logic [SAMPLE_W-1:0] lane1_data
);
    route_t                route;
    logic                  adv;
    logic [NUM_LANES-1:0]  lane_valid;
    cplx_t [NUM_LANES-1:0] lane_data;

    dsd_block_tracker #(
        .BLK_LEN    (BLK_LEN),
        .SKIP_BLKS  (SKIP_BLKS),
        .SWAP_START (SWAP_START)
    ) u_tracker (
        .clk   (clk),
        .rst   (rst),
        .adv   (adv),
        .route (route)
    );

    dsd_lane_router u_router (
        .in_valid   (in_valid),
        .in_data    (cplx_t'(in_data)),
        .route      (route),
        .lane_ready ({lane1_ready, lane0_ready}),
        .lane_valid (lane_valid),
        .lane_data  (lane_data),
        .in_ready   (in_ready),
        .adv        (adv)
    );

    assign lane0_valid = lane_valid[0];
    assign lane1_valid = lane_valid[1];
    assign lane0_data  = lane_data[0];
    assign lane1_data  = lane_data[1];

endmodule

// File: rtl/dsd_checker.sv
`timescale 1ns/1ps
module dsd_checker #(
    parameter int BLK_LEN    = 4,
    parameter int SKIP_BLKS  = 0,
    parameter bit SWAP_START = 1'b0
) (
    input logic        clk,
    input logic        rst,
    input logic        in_valid,
    input logic        in_ready,
    input logic [31:0] in_data,
    input logic        lane0_valid,
    input logic        lane0_ready,
    input logic [31:0] lane0_data,
    input logic        lane1_valid,
    input logic        lane1_ready,
    input logic [31:0] lane1_data
);
    localparam int POS_W = $clog2(BLK_LEN);
    localparam logic [POS_W-1:0] LAST_POS = POS_W'(BLK_LEN - 1);

    logic             fwd;
    logic             any_valid;
    logic [POS_W-1:0] fpos;
    logic             last_lane;
    logic             seen_blk;

    assign any_valid = lane0_valid | lane1_valid;
    assign fwd = (lane0_valid && lane0_ready) || (lane1_valid && lane1_ready);

    always_ff @(posedge clk) begin
        if (rst) begin
            fpos      <= '0;
            last_lane <= 1'b0;
            seen_blk  <= 1'b0;
        end else if (fwd) begin
            last_lane <= lane1_valid;
            fpos      <= (fpos == LAST_POS) ? '0 : fpos + 1'b1;
            if (fpos == LAST_POS) seen_blk <= 1'b1;
        end
    end

    AST_ONE_LANE: assert property (@(posedge clk) disable iff (rst)
        !(lane0_valid && lane1_valid)); // R6
    AST_VALID_NEEDS_INPUT: assert property (@(posedge clk) disable iff (rst)
        any_valid |-> in_valid); // R6
    AST_DATA_PASS0: assert property (@(posedge clk) disable iff (rst)
        lane0_valid |-> (lane0_data == in_data)); // R1
    AST_DATA_PASS1: assert property (@(posedge clk) disable iff (rst)
        lane1_valid |-> (lane1_data == in_data)); // R1
    AST_READY_FOLLOWS0: assert property (@(posedge clk) disable iff (rst)
        lane0_valid |-> (in_ready == lane0_ready)); // R7
    AST_READY_FOLLOWS1: assert property (@(posedge clk) disable iff (rst)
        lane1_valid |-> (in_ready == lane1_ready)); // R7
    AST_BLOCK_HOLD: assert property (@(posedge clk) disable iff (rst)
        (fpos != '0 && any_valid) |-> (lane1_valid == last_lane)); // R2
    AST_BLOCK_SWITCH: assert property (@(posedge clk) disable iff (rst)
        (fpos == '0 && seen_blk && any_valid) |-> (lane1_valid != last_lane)); // R2
    AST_FIRST_LANE: assert property (@(posedge clk) disable iff (rst)
        (!seen_blk && any_valid) |-> (lane1_valid == SWAP_START)); // R4
    AST_RESET_START: assert property (@(posedge clk) disable iff (rst)
        ($past(rst) && in_valid) |->
            ((SKIP_BLKS == 0) ? (SWAP_START ? lane1_valid : lane0_valid)
                              : (!any_valid && in_ready))); // R8

endmodule

bind dsd_block_distributor dsd_checker #(
    .BLK_LEN    (BLK_LEN),
    .SKIP_BLKS  (SKIP_BLKS),
    .SWAP_START (SWAP_START)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .in_valid    (in_valid),
    .in_ready    (in_ready),
    .in_data     (in_data),
    .lane0_valid (lane0_valid),
    .lane0_ready (lane0_ready),
    .lane0_data  (lane0_data),
    .lane1_valid (lane1_valid),
    .lane1_ready (lane1_ready),
    .lane1_data  (lane1_data)
);

// File: tb/dsd_block_distributor_tb.sv
`timescale 1ns/1ps
module dsd_block_distributor_tb;
    localparam int CLK_PERIOD = 10;
    localparam int NSTIM = 32;
    // each entry: {in_valid, lane0_ready, lane1_ready}
    localparam logic [2:0] STIM [NSTIM] = '{
        3'b111, 3'b111, 3'b111, 3'b111, 3'b101, 3'b111, 3'b110, 3'b111,
        3'b111, 3'b011, 3'b111, 3'b111, 3'b101, 3'b111, 3'b111, 3'b111,
        3'b110, 3'b111, 3'b111, 3'b000, 3'b111, 3'b111, 3'b100, 3'b111,
        3'b111, 3'b111, 3'b111, 3'b101, 3'b110, 3'b111, 3'b111, 3'b111
    };
    localparam bit SWAP_V [2] = '{1'b0, 1'b1};
    localparam int SKIP_V [2] = '{0, 1};

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [1:0] iv, r0, r1, ir, l0v, l1v;
    logic [31:0] din [2];
    logic [31:0] d0 [2];
    logic [31:0] d1 [2];
    int n [2];
    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dsd_block_distributor u_dut (
        .clk(clk), .rst(rst), .in_valid(iv[0]), .in_ready(ir[0]), .in_data(din[0]),
        .lane0_valid(l0v[0]), .lane0_ready(r0[0]), .lane0_data(d0[0]),
        .lane1_valid(l1v[0]), .lane1_ready(r1[0]), .lane1_data(d1[0]));

    dsd_block_distributor #(.SKIP_BLKS(1), .SWAP_START(1'b1)) u_dut_swap (
        .clk(clk), .rst(rst), .in_valid(iv[1]), .in_ready(ir[1]), .in_data(din[1]),
        .lane0_valid(l0v[1]), .lane0_ready(r0[1]), .lane0_data(d0[1]),
        .lane1_valid(l1v[1]), .lane1_ready(r1[1]), .lane1_data(d1[1]));

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // 0 = lane 0, 1 = lane 1, 2 = skipped block
    function automatic int exp_lane(int cnt, bit swap, int skip);
        if (cnt < skip * 4) return 2;
        return (((cnt - skip * 4) / 4) % 2) ^ int'(swap);
    endfunction

    function automatic logic [31:0] sample_of(int cnt);
        return {16'(cnt), ~16'(cnt)};  // real [31:16], imaginary [15:0]
    endfunction

    // One cycle on both instances: drive after the edge, compare at the falling edge.
    task automatic step(logic v, logic a, logic b);
        int el;
        logic er;
        @(posedge clk);
        #1;
        for (int k = 0; k < 2; k++) begin
            iv[k] = v; r0[k] = a; r1[k] = b;
            din[k] = sample_of(n[k]);
        end
        @(negedge clk);
        for (int k = 0; k < 2; k++) begin
            string tag;
            el = exp_lane(n[k], SWAP_V[k], SKIP_V[k]);
            er = (el == 2) ? 1'b1 : ((el == 0) ? a : b);
            if (el == 2) tag = "R5";
            else if (k == 1) tag = "R4";
            else if (n[k] < 4) tag = "R3";
            else tag = "R2";
            check(tag, {31'd0, l0v[k]}, {31'd0, v && el == 0});
            check(tag, {31'd0, l1v[k]}, {31'd0, v && el == 1});
            check("R6", {31'd0, l0v[k] & l1v[k]}, 32'd0);
            check("R7", {31'd0, ir[k]}, {31'd0, er});
            if (v && el == 0) check("R1", d0[k], sample_of(n[k]));
            if (v && el == 1) check("R1", d1[k], sample_of(n[k]));
            if (v && er) n[k]++;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        iv = '0; r0 = '1; r1 = '1;
        din[0] = '0; din[1] = '0;
        n[0] = 0; n[1] = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // reset state: nothing offered, nothing valid
        check("R8", {30'd0, l0v}, 32'd0);
        check("R8", {30'd0, l1v}, 32'd0);
        @(posedge clk);
        #1 rst = 1'b0;

        // R9: the first sample appears on its lane in the cycle it is offered
        for (int i = 0; i < NSTIM; i++) step(STIM[i][2], STIM[i][1], STIM[i][0]);

        // R8: reset in the middle of a block returns to the start lane
        step(1'b1, 1'b1, 1'b1);
        @(posedge clk);
        #1 rst = 1'b1; iv = '0;
        @(posedge clk);
        #1 rst = 1'b0;
        n[0] = 0; n[1] = 0;
        iv = '1; r0 = '1; r1 = '1;
        din[0] = sample_of(0); din[1] = sample_of(0);
        @(negedge clk);
        check("R9", {31'd0, l0v[0]}, 32'd1);
        check("R8", {31'd0, l1v[0]}, 32'd0);
        check("R5", {31'd0, l0v[1] | l1v[1]}, 32'd0);
        check("R5", {31'd0, ir[1]}, 32'd1);
        n[0] = 1; n[1] = 1;

        // R7: ready of the idle lane is ignored while the other is destined
        for (int i = 0; i < 12; i++) step(1'b1, (i % 3) != 0, (i % 2) == 0);
        for (int i = 0; i < 8; i++) step(1'b1, 1'b1, 1'b1);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule